// File: doc/BRIEF.md
# Self-Reloading Periodic Event Timer

This block counts ticks from one of two clock-enable sources and raises a sticky event flag every time a programmed interval has gone by. After each expiry it starts the next interval on its own, so software only has to enable it once and then acknowledge the flag. The interval and the tick source are locked while the timer runs: changing them means disabling, rewriting and re-enabling.

Ticks arrive as single-cycle enables on the core clock. One comes from a low-power free-running source, the other from the bus clock. When the bus clock is the chosen source and it is gated off, no ticks arrive and the count is frozen in place. The same expiries also drive a square wave onto an external pin when that output is allowed.

All configuration comes in through one write strobe that carries every field at once. No data stream passes through the block, so every pin is plain control or status with no handshake.

Top module: `periodic_tick_timer`

## Requirements
- R1: An interval value N gives an expiry every N+1 ticks of the chosen source, so N = 0 expires on every tick. `period_o` reads back the stored value, and the value resets to 0.
- R2: A write changes the stored interval only when the timer is disabled (`en_o` = 0) before the write edge. A write made while the timer runs leaves `period_o` unchanged.
- R3: Source code 0 selects `slow_tick_i` and code 1 selects `bus_tick_i`. Ticks on the unselected input have no effect. The source is stored only when the timer is disabled before the write edge, and `src_o` reads it back.
- R4: Enabling the timer starts the count at the beginning of an interval. Disabling it returns the count to zero at once, so a later enable waits a full interval.
- R5: On expiry `flag_o` becomes 1 in the cycle after the expiring tick edge. The next interval starts with no further writes.
- R6: A one-cycle `flag_clr_i` pulse clears `flag_o`. An expiry in the same cycle wins and leaves the flag set.
- R7: `irq_o` is 1 exactly when `flag_o` and the stored interrupt enable are both 1. The interrupt enable can be written at any time.
- R8: While the bus source is selected and `bus_tick_i` stays low, the count holds its value. Counting resumes from that value when ticks return.
- R9: `wave_o` toggles on every expiry while the timer and the external output are both enabled, which gives a 50% duty wave at half the expiry rate. It is 0 otherwise and starts at 0 on each enable.
- R10: After reset, `flag_o`, `irq_o`, `wave_o`, `en_o` and `src_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick_i | input | 1 | Tick enable from the low-power source (source code 0) |
| bus_tick_i | input | 1 | Tick enable from the bus clock, low when that clock is gated (source code 1) |
| cfg_wr_i | input | 1 | Write strobe for all configuration fields |
| cfg_period_i | input | 16 | Interval value to store |
| cfg_src_i | input | 1 | Tick source to store |
| cfg_en_i | input | 1 | Timer enable to store |
| cfg_irq_en_i | input | 1 | Interrupt enable to store |
| cfg_ext_en_i | input | 1 | External wave output enable to store |
| flag_clr_i | input | 1 | Pulse that clears the event flag |
| flag_o | output | 1 | Sticky expiry flag |
| irq_o | output | 1 | Interrupt request |
| wave_o | output | 1 | External square wave |
| period_o | output | 16 | Stored interval value |
| src_o | output | 1 | Stored tick source |
| en_o | output | 1 | Stored timer enable |

## Verification
The hardest case to reach is a count frozen partway through an interval. Only the internal count shows where the interval stands, and it has no pin. The stimulus selects the bus source, gives a few bus ticks, and then holds bus ticks low for a long gap while the low-power ticks keep running. After the gap it counts exactly how many more bus ticks it takes to reach the flag, and from that number it can tell a frozen count from a reset count and from an advanced one. The reset-on-disable rule is checked the same way: the timer is disabled partway through an interval, re-enabled, and the bench confirms that a full interval passes before the flag sets.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
  localparam int unsigned PERIOD_W_DEF = 16;

  typedef enum logic {
    SRC_SLOW = 1'b0,
    SRC_BUS  = 1'b1
  } ptt_src_e;

  typedef struct packed {
    ptt_src_e src;
    logic     en;
    logic     irq_en;
    logic     ext_en;
  } ptt_ctl_t;
endpackage

// File: rtl/ptt_cfg.sv
module ptt_cfg
  import ptt_pkg::*;
#(
  parameter int unsigned PERIOD_W = PERIOD_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  ptt_ctl_t            ctl_i,
  output logic [PERIOD_W-1:0] period_o,
  output ptt_ctl_t            ctl_o
);
  logic [PERIOD_W-1:0] period_q;
  ptt_ctl_t            ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      ctl_q    <= '{src: SRC_SLOW, en: 1'b0, irq_en: 1'b0, ext_en: 1'b0};
    end else if (wr_i) begin
      ctl_q.en     <= ctl_i.en;
      ctl_q.irq_en <= ctl_i.irq_en;
      ctl_q.ext_en <= ctl_i.ext_en;
      if (!ctl_q.en) begin
        period_q  <= period_i;
        ctl_q.src <= ctl_i.src;
      end
    end
  end

  assign period_o = period_q;
  assign ctl_o    = ctl_q;

  // R2
  period_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.en |=> period_q == $past(period_q));
  // R3
  src_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.en |=> ctl_q.src == $past(ctl_q.src));
endmodule

// File: rtl/ptt_count.sv
module ptt_count
  import ptt_pkg::*;
#(
  parameter int unsigned PERIOD_W = PERIOD_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  ptt_src_e            src_i,
  input  logic                slow_tick_i,
  input  logic                bus_tick_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                expire_o
);
  logic [PERIOD_W-1:0] cnt_q;
  logic                tick;

  always_comb begin
    unique case (src_i)
      SRC_BUS:  tick = bus_tick_i;
      default:  tick = slow_tick_i;
    endcase
  end

  assign expire_o = en_i && tick && (cnt_q == period_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q == period_i) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  // R1
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> cnt_q <= period_i);
  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !tick) |=> $stable(cnt_q));
  // R4
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> cnt_q == '0);
endmodule

// File: rtl/ptt_wave.sv
module ptt_wave (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic ext_en_i,
  input  logic expire_i,
  output logic wave_o
);
  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= 1'b0;
    else if (!en_i)    phase_q <= 1'b0;
    else if (expire_i) phase_q <= ~phase_q;
  end

  assign wave_o = phase_q & en_i & ext_en_i;

  // R9
  wave_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && expire_i) |=> phase_q != $past(phase_q));
  // R9
  wave_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !phase_q);
endmodule

// File: rtl/periodic_tick_timer.sv
module periodic_tick_timer
  import ptt_pkg::*;
#(
  parameter int unsigned PERIOD_W = PERIOD_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slow_tick_i,
  input  logic                bus_tick_i,
  input  logic                cfg_wr_i,
  input  logic [PERIOD_W-1:0] cfg_period_i,
  input  logic                cfg_src_i,
  input  logic                cfg_en_i,
  input  logic                cfg_irq_en_i,
  input  logic                cfg_ext_en_i,
  input  logic                flag_clr_i,
  output logic                flag_o,
  output logic                irq_o,
  output logic                wave_o,
  output logic [PERIOD_W-1:0] period_o,
  output logic                src_o,
  output logic                en_o
);
  ptt_ctl_t            ctl_in;
  ptt_ctl_t            ctl;
  logic [PERIOD_W-1:0] period;
  logic                expire;
  logic                flag_q;

  assign ctl_in = '{src: ptt_src_e'(cfg_src_i), en: cfg_en_i,
                    irq_en: cfg_irq_en_i, ext_en: cfg_ext_en_i};

  ptt_cfg #(.PERIOD_W(PERIOD_W)) cfg_u (
    .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr_i), .period_i(cfg_period_i),
    .ctl_i(ctl_in), .period_o(period), .ctl_o(ctl)
  );

  ptt_count #(.PERIOD_W(PERIOD_W)) count_u (
    .clk(clk), .rst_n(rst_n), .en_i(ctl.en), .src_i(ctl.src),
    .slow_tick_i(slow_tick_i), .bus_tick_i(bus_tick_i),
    .period_i(period), .expire_o(expire)
  );

  ptt_wave wave_u (
    .clk(clk), .rst_n(rst_n), .en_i(ctl.en), .ext_en_i(ctl.ext_en),
    .expire_i(expire), .wave_o(wave_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (expire)     flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign flag_o   = flag_q;
  assign irq_o    = flag_q & ctl.irq_en;
  assign period_o = period;
  assign src_o    = ctl.src;
  assign en_o     = ctl.en;

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_o);
  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !expire) |=> !flag_o);
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag_o);
  // R9
  wave_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_o |-> !wave_o);
endmodule

// File: tb/periodic_tick_timer_tb_top.sv
module periodic_tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick_i = 1'b0, bus_tick_i = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [15:0] cfg_period_i = '0;
  logic        cfg_src_i = 1'b0, cfg_en_i = 1'b0, cfg_irq_en_i = 1'b0, cfg_ext_en_i = 1'b0;
  logic        flag_clr_i = 1'b0;
  logic        flag_o, irq_o, wave_o, src_o, en_o;
  logic [15:0] period_o;

  int unsigned n_chk = 0, n_fail = 0;
  int unsigned cyc = 0;
  int unsigned exp_q[$];
  bit          mon_en = 1'b0;
  bit          finished = 1'b0;
  logic        wave_prev = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  periodic_tick_timer dut_i (
    .clk(clk), .rst_n(rst_n), .slow_tick_i(slow_tick_i), .bus_tick_i(bus_tick_i),
    .cfg_wr_i(cfg_wr_i), .cfg_period_i(cfg_period_i), .cfg_src_i(cfg_src_i),
    .cfg_en_i(cfg_en_i), .cfg_irq_en_i(cfg_irq_en_i), .cfg_ext_en_i(cfg_ext_en_i),
    .flag_clr_i(flag_clr_i), .flag_o(flag_o), .irq_o(irq_o), .wave_o(wave_o),
    .period_o(period_o), .src_o(src_o), .en_o(en_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int p, input bit src, input bit en, input bit ie, input bit ext);
    @(negedge clk);
    cfg_wr_i = 1'b1; cfg_period_i = 16'(p); cfg_src_i = src;
    cfg_en_i = en; cfg_irq_en_i = ie; cfg_ext_en_i = ext;
    @(negedge clk);
    cfg_wr_i = 1'b0;
  endtask

  task automatic clr_flag();
    @(negedge clk); flag_clr_i = 1'b1;
    @(negedge clk); flag_clr_i = 1'b0;
  endtask

  task automatic wait_until(input int unsigned t);
    while (cyc < t) @(negedge clk);
  endtask

  // Scoreboard monitor: every wave edge is one expiry (R9, R5, R1)
  always @(negedge clk) begin
    if (mon_en && wave_o !== wave_prev) begin
      if (exp_q.size() == 0) check(1'b0, "R5", int'(cyc), -1);
      else begin
        int unsigned e;
        e = exp_q.pop_front();
        check(cyc == e, "R1/R9 expiry cycle", int'(cyc), int'(e));
      end
    end
    wave_prev <= wave_o;
  end

  // Driver: enable with interval p, push n expected expiry cycles
  task automatic run_sb(input int p, input int n);
    int unsigned c0;
    slow_tick_i = 1'b1;
    wr(p, 1'b0, 1'b1, 1'b0, 1'b1);
    c0 = cyc;
    for (int k = 1; k <= n; k++) exp_q.push_back(c0 + (p + 1) * k);
    mon_en = 1'b1;
    wait_until(c0 + (p + 1) * n + 1);
    mon_en = 1'b0;
    check(exp_q.size() == 0, "R5 auto reload", exp_q.size(), 0);
    check(flag_o == 1'b1, "R5 flag", flag_o, 1);
    exp_q.delete();
    wr(0, 1'b0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    check(wave_o == 1'b0, "R9 low when disabled", wave_o, 0);
    clr_flag();
    check(flag_o == 1'b0, "R6 clear", flag_o, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned c0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(flag_o == 0 && irq_o == 0 && wave_o == 0, "R10 outputs", {flag_o, irq_o, wave_o}, 0);
    check(en_o == 0 && src_o == 0 && period_o == 0, "R10 cfg", int'(period_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_sb(2, 4);
    run_sb(0, 6);
    run_sb(6, 3);

    // R4: disabling mid-interval restarts the full interval
    slow_tick_i = 1'b1;
    wr(9, 1'b0, 1'b1, 1'b0, 1'b0);
    c0 = cyc;
    wait_until(c0 + 5);
    wr(9, 1'b0, 1'b0, 1'b0, 1'b0);
    clr_flag();
    wr(9, 1'b0, 1'b1, 1'b0, 1'b0);
    c0 = cyc;
    wait_until(c0 + 9);
    check(flag_o == 0, "R4 no early expiry", flag_o, 0);
    wait_until(c0 + 10);
    check(flag_o == 1, "R4 full interval", flag_o, 1);
    check(wave_o == 0, "R9 ext disabled", wave_o, 0);
    // R7: irq gating
    check(irq_o == 0, "R7 irq masked", irq_o, 0);
    wr(3, 1'b1, 1'b1, 1'b1, 1'b0);
    check(irq_o == 1, "R7 irq enabled", irq_o, 1);
    // R2/R3: writes while running ignored
    check(period_o == 9, "R2 locked", int'(period_o), 9);
    check(src_o == 0, "R3 locked", src_o, 0);
    wr(0, 1'b0, 1'b0, 1'b0, 1'b0);
    clr_flag();
    check(flag_o == 0 && irq_o == 0, "R6/R7 cleared", {flag_o, irq_o}, 0);

    // R8/R3: freeze with bus source
    slow_tick_i = 1'b0; bus_tick_i = 1'b0;
    wr(4, 1'b1, 1'b1, 1'b0, 1'b0);
    check(period_o == 4 && src_o == 1, "R2/R3 accepted while disabled", int'(period_o), 4);
    bus_tick_i = 1'b1;
    repeat (3) @(negedge clk);
    bus_tick_i = 1'b0; slow_tick_i = 1'b1;
    repeat (10) @(negedge clk);
    check(flag_o == 0, "R8/R3 frozen, slow ignored", flag_o, 0);
    bus_tick_i = 1'b1; slow_tick_i = 1'b0;
    @(negedge clk);
    check(flag_o == 0, "R8 fourth tick", flag_o, 0);
    @(negedge clk);
    check(flag_o == 1, "R8 resumed count", flag_o, 1);
    bus_tick_i = 1'b0;
    wr(16'h1234, 1'b0, 1'b1, 1'b0, 1'b0);
    check(period_o == 4 && src_o == 1, "R2 write while running ignored", int'(period_o), 4);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule